// File: doc/BRIEF.md
# Dual-Line Secondary Interrupt Controller

This block collects up to 24 level-type interrupt sources and presents them to two separate host interrupt lines. Each line has its own status and mask registers, so two bus masters can service the same sources independently. Each source passes through a two-flop synchronizer and then an edge detector. A single shared edge-configuration register selects which edges count as an event: rising, falling, both or none. An event sets the source's status bit on both lines at once. A line's active-low output is low while any of its status bits is set and not masked.

Status can be cleared in one of two ways, chosen by a control bit. In the first, a read clears the bits it returned. In the second, the host writes ones to the bits it wants cleared. If a source produces a second event while its status bit is still set, that event is held. The status bit then comes back right after the clear, so a host may need two clearing accesses to drain a busy source. Host access is through a simple synchronous port with an address, write data, write and read strobes, and read data that is registered one cycle after the read strobe.

Top module: `irq_dual_line_ctrl`

## Requirements
- R1: After reset both `irq_n` outputs are high, all mask bits read 1 (0xFF), and all status bytes, edge-configuration bytes and the control register read 0x00.
- R2: Source k has a 2-bit trigger field in edge byte k/4 at address 0x10+k/4, bit offset 2*(k mod 4). The upper bit of the field enables rising-edge events and the lower bit enables falling-edge events. An edge whose bit is clear sets nothing.
- R3: A source whose trigger field is 00 never sets a status bit on either line.
- R4: A trigger field of 11 produces an event on both edges of the source.
- R5: An event sets the source's status bit on both lines. Each line keeps private status and mask registers. `irq_n[l]` is low exactly while line l has a status bit that is set with its mask bit at 0.
- R6: A mask bit of 1 keeps that source from driving the line's output, but the status bit is still captured and can be read.
- R7: The control register sits at address 0x18, with clear-on-read in bit 0. When the bit is 1, a status read returns the current byte and clears the set bits of that byte. Writes to status bytes are then ignored.
- R8: When the clear-on-read bit is 0, a status read has no side effect. A status write clears the bits written as 1 and leaves the bits written as 0.
- R9: An event that arrives while its status bit is already set is held. The first clear leaves the bit set, and a second clear removes it.
- R10: When an event and a clear reach the same status bit in the same cycle, the bit stays set.
- R11: Line 0 status is at 0x00–0x02 and line 0 mask at 0x04–0x06. Line 1 status is at 0x08–0x0A and line 1 mask at 0x0C–0x0E. Source k sits in byte k/8, bit k mod 8. Offsets beyond the bytes the source count needs, and any unused address, read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | NUM_SRC | Asynchronous source levels |
| addr | input | 5 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe; data valid in the next cycle |
| rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt outputs, one per line |

## Verification
The hardest state to reach from the ports is a status clear that lands on the same clock edge as a new event. Reaching it needs exact knowledge of the input path: two synchronizer flops, then the edge detector's previous-sample flop. The bench changes a source and asserts the clearing write exactly two falling edges later, so both reach the status register on the same rising edge. The held second event is produced with a one-cycle pulse on a source configured for both edges. This yields a rising event and a falling event on consecutive cycles, and the bench then shows that two clears are needed on the other line.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   localparam int          MAX_SRC      = 24;
   localparam int          MIN_SYNC     = 2;
   localparam logic [4:0]  A_CTRL       = 5'h18;
   localparam int          CTRL_COR_BIT = 0;
   localparam int          NLINES       = 2;
endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irqb_edge.sv
module irqb_edge #(
   parameter int N = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   lvl,
   input  logic [2*N-1:0] trig_cfg,
   output logic [N-1:0]   ev
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         ev[i] = (lvl[i] & ~prev_q[i] & trig_cfg[2*i+1]) |
                 (~lvl[i] & prev_q[i] & trig_cfg[2*i]);
      end
   end
endmodule

// File: rtl/irqb_line.sv
module irqb_line #(
   parameter int N  = 8,
   parameter int NB = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  ev,
   input  logic [N-1:0]  clr,
   input  logic [NB-1:0] mask_we,
   input  logic [7:0]    wdata,
   output logic [N-1:0]  stat,
   output logic [N-1:0]  mask,
   output logic          irq_n
);
   logic [N-1:0] stat_q, pend_q, mask_q;
   logic [N-1:0] stat_d, pend_d;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         stat_d[i] = stat_q[i];
         pend_d[i] = pend_q[i];
         if (ev[i]) begin
            stat_d[i] = 1'b1;
            if (stat_q[i] && !clr[i]) pend_d[i] = 1'b1;
         end else if (clr[i] && stat_q[i]) begin
            stat_d[i] = pend_q[i];
            pend_d[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         pend_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= stat_d;
         pend_q <= pend_d;
         for (int i = 0; i < N; i++) begin
            if (mask_we[i/8]) mask_q[i] <= wdata[i%8];
         end
      end
   end

   assign stat  = stat_q;
   assign mask  = mask_q;
   assign irq_n = ~|(stat_q & ~mask_q);

   // R9: a held event only exists behind a set status bit
   a_r9_pend_under_stat: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~stat_q) == '0);

   // R10: an event always leaves its status bit set, clear or not
   a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

   // R8: a status bit only drops after a clear request
   a_r8_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (~stat_q & $past(stat_q) & ~$past(clr)) == '0);
endmodule

// File: rtl/irq_dual_line_ctrl.sv
module irq_dual_line_ctrl
   import irqb_pkg::*;
#(
   parameter int NUM_SRC     = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic [4:0]         addr,
   input  logic [7:0]         wdata,
   input  logic               wr_en,
   input  logic               rd_en,
   output logic [7:0]         rdata,
   output logic [1:0]         irq_n
);
   localparam int NB  = (NUM_SRC + 7) / 8;
   localparam int NEB = (NUM_SRC + 3) / 4;

   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
         $error("NUM_SRC out of range");
      end
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES too small");
      end
      if (NEB > 8) begin : g_bad_edge
         $error("edge bytes exceed address window");
      end
   endgenerate

   logic [NUM_SRC-1:0]   lvl_s, ev;
   logic [2*NUM_SRC-1:0] edge_q;
   logic                 cor_q;
   logic [NUM_SRC-1:0]   stat_l [NLINES];
   logic [NUM_SRC-1:0]   mask_l [NLINES];
   logic [NUM_SRC-1:0]   clr_l  [NLINES];
   logic [NB-1:0]        mwe_l  [NLINES];
   logic [7:0]           rd_next;
   logic                 sm_hit, edge_hit;

   assign sm_hit   = ~addr[4];
   assign edge_hit = (addr[4:3] == 2'b10);

   irqb_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(src_lvl), .q(lvl_s));

   irqb_edge #(.N(NUM_SRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .trig_cfg(edge_q), .ev(ev));

   genvar l;
   generate
      for (l = 0; l < NLINES; l++) begin : g_line
         localparam logic LSEL = 1'(l);
         logic line_hit;
         assign line_hit = sm_hit && (addr[3] == LSEL);

         always_comb begin
            for (int b = 0; b < NB; b++) begin
               mwe_l[l][b] = wr_en && line_hit && addr[2] && (addr[1:0] == 2'(b));
            end
            for (int i = 0; i < NUM_SRC; i++) begin
               clr_l[l][i] = 1'b0;
               if (line_hit && !addr[2] && (addr[1:0] == 2'(i/8))) begin
                  if (cor_q) clr_l[l][i] = rd_en;
                  else       clr_l[l][i] = wr_en & wdata[i%8];
               end
            end
         end

         irqb_line #(.N(NUM_SRC), .NB(NB)) u_line (
            .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr_l[l]),
            .mask_we(mwe_l[l]), .wdata(wdata),
            .stat(stat_l[l]), .mask(mask_l[l]), .irq_n(irq_n[l]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= '0;
         cor_q  <= 1'b0;
      end else if (wr_en) begin
         for (int i = 0; i < 2*NUM_SRC; i++) begin
            if (edge_hit && addr[2:0] == 3'(i/8)) edge_q[i] <= wdata[i%8];
         end
         if (addr == A_CTRL) cor_q <= wdata[CTRL_COR_BIT];
      end
   end

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sm_hit && addr[1:0] == 2'(i/8)) begin
            rd_next[i%8] = addr[2] ? mask_l[addr[3]][i] : stat_l[addr[3]][i];
         end
      end
      for (int i = 0; i < 2*NUM_SRC; i++) begin
         if (edge_hit && addr[2:0] == 3'(i/8)) rd_next[i%8] = edge_q[i];
      end
      if (addr == A_CTRL) rd_next[CTRL_COR_BIT] = cor_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   // checker-side view of sources that are switched off
   logic [NUM_SRC-1:0] off_vec;
   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) off_vec[i] = (edge_q[2*i +: 2] == 2'b00);
   end

   // R3: a source with field 00 never raises status on either line
   a_r3_off_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_l[0] & ~$past(stat_l[0]) & $past(off_vec)) == '0) &&
      ((stat_l[1] & ~$past(stat_l[1]) & $past(off_vec)) == '0));

   // R6: a fully masked line keeps its output released
   a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_l[0]) |-> irq_n[0]);

   // R5: lines see the same events, so a rise on one line is a rise or hold on the other
   a_r5_shared_events: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_l[0] & ~$past(stat_l[0]) & ~stat_l[1]) == '0));
endmodule

// File: tb/irq_dual_line_ctrl_tb.sv
`timescale 1ns/1ps
module irq_dual_line_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] src = '0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic [1:0]  irq_n;
   int          n_chk = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   irq_dual_line_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .irq_n(irq_n));

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(tag, $sformatf("read %02h", a), d, exp);
   endtask

   task automatic t_reset;
      chk("R1", "irq_n", {6'b0, irq_n}, 8'h03);
      rd_chk("R1", 5'h04, 8'hFF);
      rd_chk("R1", 5'h0E, 8'hFF);
      rd_chk("R1", 5'h00, 8'h00);
      rd_chk("R1", 5'h0A, 8'h00);
      rd_chk("R1", 5'h10, 8'h00);
      rd_chk("R1", 5'h18, 8'h00);
   endtask

   task automatic t_off;
      src[0] = 1'b1; idle(6);
      src[0] = 1'b0; idle(6);
      rd_chk("R3", 5'h00, 8'h00);
      rd_chk("R3", 5'h08, 8'h00);
   endtask

   task automatic t_rise;
      wr(5'h10, 8'h08);               // source 1 rising only
      wr(5'h04, 8'hFD);               // unmask source 1 on line 0
      src[1] = 1'b1; idle(5);
      chk("R5", "irq_n line0 low line1 high", {6'b0, irq_n}, 8'h02);
      rd_chk("R8", 5'h00, 8'h02);
      rd_chk("R8", 5'h00, 8'h02);     // read had no side effect
      rd_chk("R6", 5'h08, 8'h02);     // masked line still captured
      wr(5'h00, 8'h00);
      rd_chk("R8", 5'h00, 8'h02);     // zero write leaves bit
      wr(5'h00, 8'h02); idle(1);
      chk("R8", "irq_n after clear", {6'b0, irq_n}, 8'h03);
      src[1] = 1'b0; idle(5);
      rd_chk("R2", 5'h00, 8'h00);     // falling edge not enabled
      wr(5'h0C, 8'hFD); idle(1);
      chk("R5", "line1 unmasked", {6'b0, irq_n}, 8'h01);
      wr(5'h08, 8'h02); idle(1);
      chk("R5", "line1 cleared", {6'b0, irq_n}, 8'h03);
      wr(5'h0C, 8'hFF);
      wr(5'h04, 8'hFF);
   endtask

   task automatic t_both;
      wr(5'h11, 8'h0C);               // source 5 both edges
      src[5] = 1'b1; idle(5);
      rd_chk("R4", 5'h00, 8'h20);
      wr(5'h00, 8'h20); wr(5'h08, 8'h20);
      src[5] = 1'b0; idle(5);
      rd_chk("R4", 5'h00, 8'h20);
      rd_chk("R4", 5'h08, 8'h20);
      wr(5'h00, 8'h20); wr(5'h08, 8'h20);
      rd_chk("R4", 5'h00, 8'h00);
   endtask

   task automatic t_cor;
      wr(5'h18, 8'h01);
      rd_chk("R7", 5'h18, 8'h01);
      wr(5'h12, 8'h08);               // source 9 rising
      src[9] = 1'b1; idle(5);
      wr(5'h01, 8'h02);               // ignored under clear-on-read
      rd_chk("R7", 5'h01, 8'h02);
      rd_chk("R7", 5'h01, 8'h00);
      rd_chk("R5", 5'h09, 8'h02);     // line 1 kept its own copy
      rd_chk("R7", 5'h09, 8'h00);
      wr(5'h18, 8'h00);
      src[9] = 1'b0; idle(5);
   endtask

   task automatic t_buffer;
      wr(5'h14, 8'h0C);               // source 17 both edges
      src[17] = 1'b1; @(negedge clk);
      src[17] = 1'b0; idle(5);
      rd_chk("R9", 5'h02, 8'h02);
      wr(5'h02, 8'h02);
      rd_chk("R9", 5'h02, 8'h02);     // held event returns
      wr(5'h02, 8'h02);
      rd_chk("R9", 5'h02, 8'h00);
      wr(5'h0A, 8'h02);
      rd_chk("R9", 5'h0A, 8'h02);
      wr(5'h0A, 8'h02);
      rd_chk("R9", 5'h0A, 8'h00);
   endtask

   task automatic t_collide;
      wr(5'h10, 8'h0A);               // source 0 rising, source 1 kept
      src[0] = 1'b1; idle(5);
      src[0] = 1'b0; idle(5);
      rd_chk("R10", 5'h00, 8'h01);
      // new rise: two sync flops, event seen before the third edge
      src[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(5'h00, 8'h01);               // lands on the same edge as the event
      rd_chk("R10", 5'h00, 8'h01);
      wr(5'h00, 8'h01);
      rd_chk("R10", 5'h00, 8'h00);
      wr(5'h08, 8'h01);
      rd_chk("R9", 5'h08, 8'h01);
      wr(5'h08, 8'h01);
      rd_chk("R9", 5'h08, 8'h00);
      src[0] = 1'b0; idle(4);
   endtask

   task automatic t_layout;
      rd_chk("R11", 5'h03, 8'h00);
      rd_chk("R11", 5'h07, 8'h00);
      rd_chk("R11", 5'h16, 8'h00);
      rd_chk("R11", 5'h1F, 8'h00);
      wr(5'h15, 8'h80);               // source 23 rising
      wr(5'h06, 8'h7F);
      src[23] = 1'b1; idle(5);
      chk("R11", "irq_n source 23", {6'b0, irq_n}, 8'h02);
      rd_chk("R11", 5'h02, 8'h80);
      wr(5'h02, 8'h80); wr(5'h0A, 8'h80);
      wr(5'h06, 8'hFF); idle(1);
      chk("R11", "irq_n released", {6'b0, irq_n}, 8'h03);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_off();
      t_rise();
      t_both();
      t_cor();
      t_buffer();
      t_collide();
      t_layout();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule